// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns a stream of bytes into a bit-serial HDLC line signal. It emits one line bit on each rising clock edge for which the transmit enable is high. It draws bytes from a valid/take handshake and sends each byte least significant bit first. A frame is opened with a flag, the data bits follow, a 16-bit frame check sequence comes next, and a closing flag ends the frame. A zero is inserted after every run of five ones inside the data and the check sequence.

When no frame is in progress, the block sends an interframe fill chosen by the host: steady ones, repeated flags or repeated abort patterns. A frame-open command ends the fill at the next bit, even in the middle of a fill byte. The host can abort a frame at any time. The block also aborts a frame by itself when the byte source has no byte ready at the moment one is needed. The final byte of a frame can carry from one to eight valid bits, and the check sequence can be left out.

A one-cycle interrupt is raised when the last byte of a frame is taken and when an underrun occurs. A status field keeps the cause of the most recent interrupt. While the enable is low the block is frozen and its output driver is released.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After a synchronous reset, `tx_oe`, `irq`, `stat` and `src_take` are all 0. The first fill bit that follows comes from bit 0 of the selected fill byte.
- R2: A rising edge with `tx_en` high puts exactly one new line bit on `tx_bit` and sets `tx_oe` to 1 after that edge. A rising edge with `tx_en` low sets `tx_oe` to 0 and freezes all sequencing, so no line bit is lost or repeated.
- R3: A frame is sent in this order: the flag 0x7E, the data bytes least significant bit first, the check sequence, and a closing flag 0x7E. After the closing flag, the fill restarts from bit 0 of its pattern.
- R4: After five consecutive ones in data or check-sequence bits, one extra 0 is sent. This holds even when a flag or an abort comes next. Flag, abort and fill bits are never stuffed, and they clear the run of ones.
- R5: The check sequence is the ones' complement of a 16-bit register sent from bit 15 down to bit 0. The register is preset to 0xFFFF at the opening flag. For each data bit d in send order it is updated as `c = (c<<1) ^ ((d ^ c[15]) ? 0x1021 : 0)`.
- R6: When the final byte is taken, `last_bits` gives how many of its low-order bits are sent: 1 to 7, and 0 means all 8.
- R7: When `crc_off` is 1, the closing flag follows the last data bit directly and no check sequence is sent.
- R8: `fill_sel` selects the interframe fill: 00 is steady ones, 01 or 11 is repeated 0x7E, and 10 is repeated aborts (0 followed by seven 1s). Each fill byte is sent bit 0 first.
- R9: A pulse on `frame_go` starts the opening flag at the next enabled bit and cuts off any partly sent fill byte. A pulse that arrives while disabled or during a frame is held until it can take effect.
- R10: A pulse on `abort_cmd` makes the next enabled bit the 0 of an abort, followed by seven 1s, and no zero is inserted before it. The fill then restarts from bit 0.
- R11: If `src_valid` is low when a byte is needed, the bit in flight is finished and an abort follows. `irq` is then high for one cycle with `stat` = 2'b10.
- R12: The cycle after the byte marked `src_last` is taken, `irq` is high for one cycle with `stat` = 2'b01.
- R13: A byte is consumed at a rising edge only when `src_take` is high, and `src_take` is never high without `src_valid`. Each frame takes each byte exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, one line bit per enabled edge |
| fill_sel | input | 2 | Interframe fill select |
| crc_off | input | 1 | Suppress the check sequence |
| last_bits | input | 3 | Valid bit count of the final byte (0 = 8) |
| frame_go | input | 1 | Open a new frame |
| abort_cmd | input | 1 | Abort request |
| src_valid | input | 1 | Byte source has a byte ready |
| src_data | input | 8 | Byte from the source |
| src_last | input | 1 | Byte is the last of its frame |
| src_take | output | 1 | Byte is consumed at this edge |
| tx_bit | output | 1 | Registered serial line bit |
| tx_oe | output | 1 | Line driver enable, low means released |
| irq | output | 1 | One-cycle interrupt pulse |
| stat | output | 2 | Cause of the last interrupt: bit 0 end of message, bit 1 underrun |

## Verification
The bench builds the block with its default parameters: a 16-bit check register with polynomial 0x1021 preset to all ones, and zero insertion after runs of five ones. These values let the bench's own bit-stream builder predict every line bit exactly. Bytes of 0xFF and random data with a bias toward ones drive the insertion logic at every frame position, including the edges next to flags and aborts. The 3-bit valid-count field and the suppression bit reach the short final byte and the closing flag that comes without a check sequence. Enable gaps, fill prefixes of random length and an abort placed at a chosen bit reach the pending-command paths.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_FILL,
    S_OPEN,
    S_DATA,
    S_CRC,
    S_CLOSE,
    S_ABORT
  } seq_st_t;

  localparam logic [BYTE_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_PAT = 8'hFE;
  localparam logic [BYTE_W-1:0] ONES_PAT  = 8'hFF;

  function automatic logic [BYTE_W-1:0] fill_pattern(input logic [1:0] sel);
    case (sel)
      2'b00:   return ONES_PAT;
      2'b10:   return ABORT_PAT;
      default: return FLAG_PAT;
    endcase
  endfunction
endpackage

// File: rtl/hdlc_crc_ser.sv
module hdlc_crc_ser #(
  parameter int             CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic fb;
  assign fb = din ^ crc[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc <= CRC_INIT;
    end else if (shift) begin
      crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end
endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic kill,
  input  logic raw,
  input  logic stuffable,
  output logic ins_now
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] ones;

  assign ins_now = (ones == RUN_W'(RUN_LEN)) && !kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones <= '0;
    end else if (step) begin
      if (kill || ins_now) begin
        ones <= '0;
      end else if (stuffable && raw) begin
        ones <= ones + 1'b1;
      end else begin
        ones <= '0;
      end
    end
  end

  // R4: a run never grows past the limit without an insertion
  assert_run_cap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !kill && ones == RUN_W'(RUN_LEN)) |=> (ones == '0));
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_en,
  input  logic                    ins_now,
  input  logic                    frame_go,
  input  logic                    abort_cmd,
  input  logic [1:0]              fill_sel,
  input  logic                    crc_off,
  input  logic [$clog2(BYTE_W)-1:0] last_bits,
  input  logic                    src_valid,
  input  logic [BYTE_W-1:0]       src_data,
  input  logic                    src_last,
  input  logic [CRC_W-1:0]        crc_val,
  output logic                    raw_bit,
  output logic                    stuffable,
  output logic                    abort_go,
  output logic                    src_take,
  output logic                    crc_init,
  output logic                    crc_shift,
  output logic                    underrun,
  output logic                    eom
);
  localparam int CNT_W = $clog2((CRC_W > BYTE_W) ? CRC_W : BYTE_W);
  localparam int LIM_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W - 1);

  seq_st_t           st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [LIM_W-1:0]  lim;
  logic              lastb;
  logic              go_pend;
  logic              abt_pend;

  logic             adv;
  logic             start;
  logic             fetch_pt;
  logic [CNT_W-1:0] lim_end;
  logic [CRC_W-1:0] crc_n;
  logic [BYTE_W-1:0] fpat;

  assign adv      = tx_en && !ins_now;
  assign abort_go = tx_en && (abort_cmd || abt_pend) && (st != S_ABORT);
  assign start    = (st == S_FILL) && (frame_go || go_pend) && !abort_go;
  assign lim_end  = CNT_W'(lim) - 1'b1;
  assign fetch_pt = ((st == S_OPEN) && (cnt == BYTE_END)) ||
                    ((st == S_DATA) && (cnt == lim_end) && !lastb);
  assign src_take  = adv && !abort_go && fetch_pt && src_valid;
  assign underrun  = adv && !abort_go && fetch_pt && !src_valid;
  assign eom       = src_take && src_last;
  assign crc_init  = adv && start;
  assign crc_shift = adv && !abort_go && (st == S_DATA);
  assign crc_n     = ~crc_val;
  assign fpat      = fill_pattern(fill_sel);

  always_comb begin
    raw_bit   = 1'b1;
    stuffable = 1'b0;
    if (abort_go) begin
      raw_bit = 1'b0;
    end else begin
      case (st)
        S_FILL:  raw_bit = start ? 1'b0 : fpat[cnt[2:0]];
        S_OPEN,
        S_CLOSE: raw_bit = FLAG_PAT[cnt[2:0]];
        S_DATA: begin
          raw_bit   = sh[0];
          stuffable = 1'b1;
        end
        S_CRC: begin
          raw_bit   = crc_n[CRC_END - cnt];
          stuffable = 1'b1;
        end
        S_ABORT: raw_bit = ABORT_PAT[cnt[2:0]];
        default: raw_bit = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_FILL;
      cnt      <= '0;
      sh       <= '0;
      lim      <= LIM_W'(BYTE_W);
      lastb    <= 1'b0;
      go_pend  <= 1'b0;
      abt_pend <= 1'b0;
    end else begin
      if (adv && start) go_pend <= 1'b0;
      else if (frame_go) go_pend <= 1'b1;

      if (abort_go || st == S_ABORT) abt_pend <= 1'b0;
      else if (abort_cmd) abt_pend <= 1'b1;

      if (adv) begin
        if (abort_go) begin
          st  <= S_ABORT;
          cnt <= CNT_W'(1);
        end else begin
          case (st)
            S_FILL: begin
              if (start) begin
                st  <= S_OPEN;
                cnt <= CNT_W'(1);
              end else begin
                cnt <= {{(CNT_W-3){1'b0}}, cnt[2:0] + 3'd1};
              end
            end
            S_OPEN, S_DATA: begin
              if (st == S_DATA) sh <= sh >> 1;
              if (fetch_pt) begin
                cnt <= '0;
                if (src_valid) begin
                  st    <= S_DATA;
                  sh    <= src_data;
                  lastb <= src_last;
                  lim   <= (src_last && last_bits != '0) ? LIM_W'(last_bits) : LIM_W'(BYTE_W);
                end else begin
                  st <= S_ABORT;
                end
              end else if (st == S_DATA && cnt == lim_end) begin
                cnt <= '0;
                st  <= crc_off ? S_CLOSE : S_CRC;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_CRC: begin
              if (cnt == CRC_END) begin
                st  <= S_CLOSE;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: begin
              if (cnt == BYTE_END) begin
                st  <= S_FILL;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  // R2: disabled edges freeze the sequencer
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> ($stable(st) && $stable(cnt)));
  // R10: an abort command takes over at the next enabled bit
  assert_abort_entry_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_en && abort_cmd && st != S_ABORT) |=> (st == S_ABORT && cnt == CNT_W'(1)));
  // R13: no byte is consumed without a valid byte
  assert_take_valid_R13: assert property (@(posedge clk) disable iff (rst)
    src_take |-> (src_valid && (st == S_OPEN || st == S_DATA)));
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter int               RUN_LEN  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tx_en,
  input  logic [1:0]  fill_sel,
  input  logic        crc_off,
  input  logic [2:0]  last_bits,
  input  logic        frame_go,
  input  logic        abort_cmd,
  input  logic        src_valid,
  input  logic [7:0]  src_data,
  input  logic        src_last,
  output logic        src_take,
  output logic        tx_bit,
  output logic        tx_oe,
  output logic        irq,
  output logic [1:0]  stat
);
  logic             raw_bit;
  logic             stuffable;
  logic             abort_go;
  logic             ins_now;
  logic             crc_init;
  logic             crc_shift;
  logic             underrun;
  logic             eom;
  logic [CRC_W-1:0] crc_val;

  hdlc_tx_seq #(.CRC_W(CRC_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .ins_now   (ins_now),
    .frame_go  (frame_go),
    .abort_cmd (abort_cmd),
    .fill_sel  (fill_sel),
    .crc_off   (crc_off),
    .last_bits (last_bits),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_last  (src_last),
    .crc_val   (crc_val),
    .raw_bit   (raw_bit),
    .stuffable (stuffable),
    .abort_go  (abort_go),
    .src_take  (src_take),
    .crc_init  (crc_init),
    .crc_shift (crc_shift),
    .underrun  (underrun),
    .eom       (eom)
  );

  hdlc_zero_ins #(.RUN_LEN(RUN_LEN)) zins_i (
    .clk       (clk),
    .rst       (rst),
    .step      (tx_en),
    .kill      (abort_go),
    .raw       (raw_bit),
    .stuffable (stuffable),
    .ins_now   (ins_now)
  );

  hdlc_crc_ser #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) crc_i (
    .clk   (clk),
    .rst   (rst),
    .init  (crc_init),
    .shift (crc_shift),
    .din   (raw_bit),
    .crc   (crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit <= 1'b1;
      tx_oe  <= 1'b0;
      irq    <= 1'b0;
      stat   <= 2'b00;
    end else begin
      tx_oe <= tx_en;
      if (tx_en) tx_bit <= ins_now ? 1'b0 : raw_bit;
      irq <= eom || underrun;
      if (eom || underrun) stat <= {underrun, eom};
    end
  end

  // R2: driver follows the enable of the previous edge
  assert_oe_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !tx_oe);
  // R4: an insertion puts a 0 on the line
  assert_zero_ins_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && ins_now) |=> !tx_bit);
  // R12: taking the last byte raises the end-of-message interrupt
  assert_eom_irq_R12: assert property (@(posedge clk) disable iff (rst)
    (src_take && src_last) |=> (irq && stat == 2'b01));
  // R11: an underrun raises the error interrupt
  assert_underrun_irq_R11: assert property (@(posedge clk) disable iff (rst)
    underrun |=> (irq && stat == 2'b10));
endmodule

// File: tb/hdlc_frame_tx_tb_top.sv
module hdlc_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic [1:0] fill_sel = 2'b00;
  logic       crc_off = 1'b0;
  logic [2:0] last_bits = 3'd0;
  logic       frame_go = 1'b0;
  logic       abort_cmd = 1'b0;
  logic       src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic       src_last = 1'b0;
  logic       src_take;
  logic       tx_bit;
  logic       tx_oe;
  logic       irq;
  logic [1:0] stat;

  always #4 clk = ~clk;

  hdlc_frame_tx dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fill_sel(fill_sel), .crc_off(crc_off),
    .last_bits(last_bits), .frame_go(frame_go), .abort_cmd(abort_cmd),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .src_take(src_take), .tx_bit(tx_bit), .tx_oe(tx_oe), .irq(irq), .stat(stat)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit   exp_b [0:2047];
  int   exp_n;
  int   ones_run;
  logic [7:0] fr_data [0:15];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Append one line bit; stuffable bits feed the five-ones rule (R4)
  task automatic push(input bit b, input bit stf);
    exp_b[exp_n] = b;
    exp_n++;
    if (stf) begin
      if (b) ones_run++; else ones_run = 0;
      if (ones_run == 5) begin
        exp_b[exp_n] = 1'b0;
        exp_n++;
        ones_run = 0;
      end
    end else begin
      ones_run = 0;
    end
  endtask

  task automatic push_byte(input logic [7:0] p, input bit stf, input int nb);
    for (int i = 0; i < nb; i++) push(p[i], stf);
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input bit d);
    logic fb;
    fb = d ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [7:0] fpat(input int sel);
    if (sel == 0) return 8'hFF;
    if (sel == 2) return 8'hFE;
    return 8'h7E;
  endfunction

  // R3/R5/R6/R7 frame image; without a last byte it ends in an abort (R11)
  task automatic build_frame(input int nbytes, input int lb, input bit coff, input bit wl);
    logic [15:0] c;
    int nb;
    c = 16'hFFFF;
    push_byte(8'h7E, 1'b0, 8);
    for (int k = 0; k < nbytes; k++) begin
      nb = (wl && k == nbytes - 1) ? ((lb == 0) ? 8 : lb) : 8;
      for (int i = 0; i < nb; i++) begin
        push(fr_data[k][i], 1'b1);
        c = crc_step(c, fr_data[k][i]);
      end
    end
    if (wl) begin
      if (!coff) for (int i = 15; i >= 0; i--) push(~c[i], 1'b1);
      push_byte(8'h7E, 1'b0, 8);
    end else begin
      push_byte(8'hFE, 1'b0, 8);
    end
  endtask

  task automatic do_reset(input int fsel);
    rst = 1'b1; tx_en = 1'b0; frame_go = 1'b0; abort_cmd = 1'b0;
    src_valid = 1'b0; src_last = 1'b0; fill_sel = 2'(fsel);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_oe == 1'b0 && irq == 1'b0 && stat == 2'b00 && src_take == 1'b0,
          "R1", "reset outputs {oe,irq,stat,take}",
          int'({tx_oe, irq, stat, src_take}), 0);
  endtask

  task automatic run_case(input int nbytes, input int lb, input bit coff, input bit wl,
                          input int fsel, input int pre, input bit gaps,
                          input int abort_at, input string tag);
    int cap, n_bad, first_bad, oe_bad, take_bad, idx, irq_cnt, cyc, fs, exp_irq;
    logic [1:0] irq_stat, exp_stat;
    bit took, go_done, ab_done, prev_en;
    crc_off = coff;
    last_bits = 3'(lb);
    do_reset(fsel);
    exp_n = 0; ones_run = 0;
    for (int i = 0; i < pre; i++) push(fpat(fsel)[i % 8], 1'b0);
    fs = exp_n;
    build_frame(nbytes, lb, coff, wl);
    if (abort_at >= 0) begin
      exp_n = fs + abort_at;
      push_byte(8'hFE, 1'b0, 8);
    end
    push_byte(fpat(fsel), 1'b0, 8);
    cap = 0; n_bad = 0; first_bad = -1; oe_bad = 0; take_bad = 0;
    idx = 0; irq_cnt = 0; irq_stat = 2'b00; took = 1'b0; go_done = 1'b0;
    ab_done = 1'b0; prev_en = 1'b0; cyc = 0;
    while (cap < exp_n && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (tx_oe != prev_en) oe_bad++;
      if (tx_oe) begin
        if (tx_bit !== exp_b[cap]) begin
          n_bad++;
          if (first_bad < 0) first_bad = cap;
        end
        cap++;
      end
      if (irq) begin irq_cnt++; irq_stat = stat; end
      if (took) begin
        if (!src_valid) take_bad++;
        idx++;
      end
      src_valid = (idx < nbytes);
      src_data  = fr_data[(idx < 16) ? idx : 15];
      src_last  = wl && (idx == nbytes - 1);
      frame_go  = 1'b0;
      abort_cmd = 1'b0;
      if (!go_done && cap == pre) begin frame_go = 1'b1; go_done = 1'b1; end
      else if (abort_at >= 0 && go_done && !ab_done && cap == pre + abort_at) begin
        abort_cmd = 1'b1; ab_done = 1'b1;
      end
      tx_en = gaps ? ($urandom % 4 != 0) : 1'b1;
      prev_en = tx_en;
      #2;
      took = src_take;
    end
    frame_go = 1'b0; abort_cmd = 1'b0; src_valid = 1'b0;
    check(n_bad == 0 && cap == exp_n, tag, "line bits wrong (count, first index)",
          n_bad, first_bad);
    check(oe_bad == 0, "R2", "driver enable mismatches", oe_bad, 0);
    exp_irq  = (abort_at >= 0) ? 0 : 1;
    exp_stat = wl ? 2'b01 : 2'b10;
    check(irq_cnt == exp_irq, wl ? "R12" : "R11", "interrupt pulses", irq_cnt, exp_irq);
    if (exp_irq == 1)
      check(irq_stat == exp_stat, wl ? "R12" : "R11", "status", int'(irq_stat), int'(exp_stat));
    if (abort_at < 0)
      check(idx == nbytes && take_bad == 0, "R13", "bytes taken", idx, nbytes);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nb, lb, fs, pre;
    void'($urandom(32'd4711));

    // All-ones data: stuffing inside data and next to the closing flag (R4, R5)
    for (int k = 0; k < 3; k++) fr_data[k] = 8'hFF;
    run_case(3, 0, 1'b0, 1'b1, 0, 0, 1'b0, -1, "R3/R4/R5");

    // One-bit last byte (R6)
    fr_data[0] = 8'h01;
    run_case(1, 1, 1'b0, 1'b1, 0, 0, 1'b0, -1, "R6");

    // Suppressed check sequence with 3-bit tail (R7, R6)
    fr_data[0] = 8'hF8; fr_data[1] = 8'h1F;
    run_case(2, 3, 1'b1, 1'b1, 0, 0, 1'b0, -1, "R7/R6");

    // Flag fill cut after 3 bits (R8, R9)
    fr_data[0] = 8'hA5; fr_data[1] = 8'h3C;
    run_case(2, 0, 1'b0, 1'b1, 1, 3, 1'b0, -1, "R8/R9");

    // Abort fill cut mid-byte (R8, R9)
    fr_data[0] = 8'h7E;
    run_case(1, 0, 1'b0, 1'b1, 2, 11, 1'b0, -1, "R8/R9");

    // Underrun after two bytes and before the first byte (R11)
    fr_data[0] = 8'hFF; fr_data[1] = 8'h1F;
    run_case(2, 0, 1'b0, 1'b0, 0, 0, 1'b0, -1, "R11");
    run_case(0, 0, 1'b0, 1'b0, 1, 2, 1'b0, -1, "R11");

    // Host abort inside a long frame (R10)
    for (int k = 0; k < 8; k++) fr_data[k] = 8'hFF;
    run_case(8, 0, 1'b0, 1'b1, 0, 0, 1'b0, 13, "R10");

    // Random frames with enable gaps (R2, R3, R4, R5, R6, R7, R8, R9)
    for (int t = 0; t < 10; t++) begin
      nb  = 1 + ($urandom % 6);
      lb  = $urandom % 8;
      fs  = $urandom % 4;
      pre = $urandom % 16;
      for (int k = 0; k < nb; k++)
        fr_data[k] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom | $urandom);
      run_case(nb, lb, 1'($urandom % 2), 1'b1, fs, pre, 1'b1, -1, "R2/R3/R4/R5/R6/R8");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule